// File: doc/BRIEF.md
# Data Address Breakpoint Matcher

This block sits beside a processor's load/store unit and examines every data access address the core presents. It first relocates the address into the current process slot: when the seven most significant address bits are all zero and a non-zero process identifier is configured, the identifier is merged into those bits. The relocated address is what every later check uses, and it is handed back to the core.

Two checks then run on the relocated access in the same cycle. An optional alignment check raises a one-cycle abort for any address whose two low bits are not zero, and it latches a fault status code and the faulting address. Two data-address comparators watch for debug breakpoints. Each has its own two-bit enable that selects stores, loads or both. A mask mode turns the second breakpoint register into an inverted bit mask for the first comparator. A hit produces a one-cycle pulse. When debug is enabled, the hit also comes with a write strobe and the data-breakpoint method-of-entry code for the debug status register.

All results are registered: they appear on the clock edge after the access is presented.

Top module: `daddr_watch`

## Requirements
- R1: `relAddr` equals `accAddr` with `pidField` OR-ed into bits 31:25 when `pidField` is non-zero and `accAddr[31:25]` is zero. In every other case it equals `accAddr` unchanged. It is valid, with `outValid` high, on the cycle after the access.
- R2: When `alignChkEn` is high and `accAddr[1:0]` is not zero, `abortPulse` is high for one cycle after the access. In that same cycle `faultStatus` becomes 11'h400 and `faultAddr` becomes the relocated address. Both hold their values until the next abort. With `alignChkEn` low, no abort is raised.
- R3: A comparator's two-bit enable has four values. 0 turns it off, 1 matches stores only (`accStore`=1), 3 matches loads only (`accStore`=0), and 2 matches both.
- R4: `bpCtrl[1:0]` is the enable of comparator 0, which compares against `bpAddr0`. `bpCtrl[3:2]` is the enable of comparator 1, which compares against `bpAddr1`. `bpCtrl[4]` selects mask mode.
- R5: In normal mode a comparator matches when the relocated address and its register are equal in bits 31:2. Bits 1:0 are ignored.
- R6: In mask mode, comparator 0 ignores every bit position that is set in `bpAddr1` and compares all the other bits, including bits 1:0. Comparator 1 never matches in this mode.
- R7: On a hit with `dbgEnable` high, `moeWe` pulses together with `bpHit` and `moeCode` carries 3'b010. With `dbgEnable` low, `moeWe` stays low and `moeCode` stays 0.
- R8: An access that raises an alignment abort never produces a breakpoint hit.
- R9: `bpHit`, `abortPulse`, `moeWe` and `outValid` are single-cycle pulses, registered one cycle after an access with `accValid` high. They stay low after a cycle without an access, and `faultAddr` is unchanged by such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 32 | Access address from the core |
| accStore | input | 1 | 1 for a store, 0 for a load |
| pidField | input | 7 | Process identifier used for relocation |
| alignChkEn | input | 1 | Enables the alignment abort |
| bpAddr0 | input | 32 | Breakpoint register 0 |
| bpAddr1 | input | 32 | Breakpoint register 1, or an inverted mask in mask mode |
| bpCtrl | input | 5 | Comparator enables and mask-mode select |
| dbgEnable | input | 1 | Debug enabled; gates the method-of-entry update |
| relAddr | output | 32 | Relocated address of the last access |
| outValid | output | 1 | Pulse: relAddr refreshed |
| abortPulse | output | 1 | Pulse: alignment abort |
| faultStatus | output | 11 | Latched fault status code |
| faultAddr | output | 32 | Latched faulting address |
| bpHit | output | 1 | Pulse: data breakpoint hit |
| moeWe | output | 1 | Pulse: write method-of-entry into debug status |
| moeCode | output | 3 | Method-of-entry code for the data breakpoint |

## Verification
Every cycle, the assertions check several rules. A hit and an abort never occur together. A method-of-entry write never occurs without a hit. Every pulse traces back to an access in the previous cycle. An abort traces back to a misaligned address with checking enabled. In mask mode only comparator 0 can cause a hit. A latched fault address is always misaligned. A non-zero identifier always leaves the relocated top bits non-zero. Only the bench's scenarios can show that the exact store/load encodings, the masked and unmasked comparisons, and the relocated values are correct, because those need an independent reference model.

// File: rtl/daddr_watch_pkg.sv
package daddr_watch_pkg;

  localparam int NUM_CMP = 2;

  typedef enum logic [1:0] {
    EN_OFF   = 2'd0,
    EN_STORE = 2'd1,
    EN_BOTH  = 2'd2,
    EN_LOAD  = 2'd3
  } cmpEn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic abort;
  } dpStrobe_t;

  // R3: decode of a comparator enable against the access direction
  function automatic logic enAllows(input logic [1:0] en, input logic isStore);
    logic ok;
    case (en)
      EN_OFF:   ok = 1'b0;
      EN_STORE: ok = isStore;
      EN_LOAD:  ok = !isStore;
      default:  ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/daddr_watch_dp.sv
module daddr_watch_dp
  import daddr_watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W = 7,
  parameter int ALIGN_W = 2,
  parameter int FSR_W = 11,
  parameter logic [FSR_W-1:0] FAULT_CODE = 11'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [PID_W-1:0]  pidField,
  input  logic [ADDR_W-1:0] bpAddr0,
  input  logic [ADDR_W-1:0] bpAddr1,
  input  logic              maskMode,
  input  dpStrobe_t         strobes,
  output logic              misaligned,
  output logic [NUM_CMP-1:0] cmpMatch,
  output logic [ADDR_W-1:0] relAddr,
  output logic [FSR_W-1:0]  faultStatus,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int TOP_LSB = ADDR_W - PID_W;
  localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};

  logic              topZero;
  logic [ADDR_W-1:0] relNow;
  logic [ADDR_W-1:0] bpReg   [NUM_CMP];
  logic [ADDR_W-1:0] cmpMask [NUM_CMP];

  // R1: process relocation
  assign topZero = (accAddr[ADDR_W-1:TOP_LSB] == '0);
  assign relNow  = topZero ? (accAddr | {pidField, {TOP_LSB{1'b0}}}) : accAddr;

  // R2: low bits are not touched by relocation
  assign misaligned = |accAddr[ALIGN_W-1:0];

  assign bpReg[0] = bpAddr0;
  assign bpReg[1] = bpAddr1;

  // R5/R6: per-comparator masked equality
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    if (i == 0) begin : g_first
      assign cmpMask[i] = maskMode ? ~bpAddr1 : LOW_MASK;
    end else begin : g_other
      assign cmpMask[i] = LOW_MASK;
    end
    assign cmpMatch[i] = (((relNow ^ bpReg[i]) & cmpMask[i]) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relAddr     <= '0;
      faultStatus <= '0;
      faultAddr   <= '0;
    end else begin
      if (strobes.capture) relAddr <= relNow;
      if (strobes.abort) begin
        faultStatus <= FAULT_CODE;
        faultAddr   <= relNow;
      end
    end
  end

  // R2: a latched fault address only changes on an abort strobe
  a_r2_fault_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.abort) && $past(rstN) |-> $stable(faultAddr));

endmodule

// File: rtl/daddr_watch_ctl.sv
module daddr_watch_ctl
  import daddr_watch_pkg::*;
#(
  parameter int CTRL_W = 5,
  parameter int MOE_W = 3,
  parameter logic [MOE_W-1:0] MOE_DBP = 3'b010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accStore,
  input  logic               alignChkEn,
  input  logic               dbgEnable,
  input  logic [CTRL_W-1:0]  bpCtrl,
  input  logic               misaligned,
  input  logic [NUM_CMP-1:0] cmpMatch,
  output logic               maskMode,
  output dpStrobe_t          strobes,
  output logic               outValid,
  output logic               abortPulse,
  output logic               bpHit,
  output logic               moeWe,
  output logic [MOE_W-1:0]   moeCode
);

  logic [1:0] en0, en1;
  logic       abortNow, qual0, qual1, hitNow, moeNow;

  // R4: field positions
  assign en0      = bpCtrl[1:0];
  assign en1      = bpCtrl[3:2];
  assign maskMode = bpCtrl[4];

  assign abortNow = accValid && alignChkEn && misaligned;
  assign qual0    = enAllows(en0, accStore) && cmpMatch[0];
  assign qual1    = !maskMode && enAllows(en1, accStore) && cmpMatch[1];
  assign hitNow   = accValid && !abortNow && (qual0 || qual1);
  assign moeNow   = hitNow && dbgEnable;

  assign strobes.capture = accValid;
  assign strobes.abort   = abortNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      abortPulse <= 1'b0;
      bpHit      <= 1'b0;
      moeWe      <= 1'b0;
      moeCode    <= '0;
    end else begin
      outValid   <= accValid;
      abortPulse <= abortNow;
      bpHit      <= hitNow;
      moeWe      <= moeNow;
      moeCode    <= moeNow ? MOE_DBP : '0;
    end
  end

  a_r8_abort_blocks_hit: assert property (@(posedge clk) disable iff (!rstN)
    !(abortPulse && bpHit));

  a_r7_moe_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    moeWe |-> bpHit && (moeCode == MOE_DBP));

  a_r9_pulse_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    (bpHit || abortPulse) |-> outValid);

  a_r2_abort_cause: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(alignChkEn && misaligned));

  a_r6_mask_only_cmp0: assert property (@(posedge clk) disable iff (!rstN)
    bpHit && $past(maskMode) |-> $past(qual0));

endmodule

// File: rtl/daddr_watch.sv
module daddr_watch
  import daddr_watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W = 7,
  parameter int ALIGN_W = 2,
  parameter int FSR_W = 11,
  parameter logic [FSR_W-1:0] FAULT_CODE = 11'h400,
  parameter int MOE_W = 3,
  parameter logic [MOE_W-1:0] MOE_DBP = 3'b010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStore,
  input  logic [PID_W-1:0]  pidField,
  input  logic              alignChkEn,
  input  logic [ADDR_W-1:0] bpAddr0,
  input  logic [ADDR_W-1:0] bpAddr1,
  input  logic [4:0]        bpCtrl,
  input  logic              dbgEnable,
  output logic [ADDR_W-1:0] relAddr,
  output logic              outValid,
  output logic              abortPulse,
  output logic [FSR_W-1:0]  faultStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              bpHit,
  output logic              moeWe,
  output logic [MOE_W-1:0]  moeCode
);

  localparam int CTRL_W  = 5;
  localparam int TOP_LSB = ADDR_W - PID_W;

  dpStrobe_t          strobes;
  logic               maskMode;
  logic               misaligned;
  logic [NUM_CMP-1:0] cmpMatch;

  daddr_watch_ctl #(.CTRL_W(CTRL_W), .MOE_W(MOE_W), .MOE_DBP(MOE_DBP)) u_ctl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accStore(accStore),
    .alignChkEn(alignChkEn), .dbgEnable(dbgEnable), .bpCtrl(bpCtrl),
    .misaligned(misaligned), .cmpMatch(cmpMatch), .maskMode(maskMode),
    .strobes(strobes), .outValid(outValid), .abortPulse(abortPulse),
    .bpHit(bpHit), .moeWe(moeWe), .moeCode(moeCode)
  );

  daddr_watch_dp #(.ADDR_W(ADDR_W), .PID_W(PID_W), .ALIGN_W(ALIGN_W),
                   .FSR_W(FSR_W), .FAULT_CODE(FAULT_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .pidField(pidField),
    .bpAddr0(bpAddr0), .bpAddr1(bpAddr1), .maskMode(maskMode),
    .strobes(strobes), .misaligned(misaligned), .cmpMatch(cmpMatch),
    .relAddr(relAddr), .faultStatus(faultStatus), .faultAddr(faultAddr)
  );

  a_r1_reloc_top_set: assert property (@(posedge clk) disable iff (!rstN)
    outValid && ($past(pidField) != '0) |-> (relAddr[ADDR_W-1:TOP_LSB] != '0));

  a_r2_fault_addr_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (faultAddr[ALIGN_W-1:0] != '0) && (faultStatus == FAULT_CODE));

endmodule

// File: tb/daddr_watch_tb.sv
module daddr_watch_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid;
  logic [31:0] accAddr;
  logic        accStore;
  logic [6:0]  pidField;
  logic        alignChkEn;
  logic [31:0] bpAddr0, bpAddr1;
  logic [4:0]  bpCtrl;
  logic        dbgEnable;
  logic [31:0] relAddr;
  logic        outValid, abortPulse, bpHit, moeWe;
  logic [10:0] faultStatus;
  logic [31:0] faultAddr;
  logic [2:0]  moeCode;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;
  logic [31:0] expFa = '0;
  logic [10:0] expFs = '0;

  always #5 clk = ~clk;

  daddr_watch u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accStore(accStore), .pidField(pidField), .alignChkEn(alignChkEn),
    .bpAddr0(bpAddr0), .bpAddr1(bpAddr1), .bpCtrl(bpCtrl),
    .dbgEnable(dbgEnable), .relAddr(relAddr), .outValid(outValid),
    .abortPulse(abortPulse), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .bpHit(bpHit), .moeWe(moeWe), .moeCode(moeCode)
  );

  function automatic logic [31:0] refReloc(input logic [31:0] a, input logic [6:0] p);
    if (p != 0 && a[31:25] == 0) return a | {p, 25'd0};
    return a;
  endfunction

  function automatic bit refAllow(input logic [1:0] en, input bit st);
    case (en)
      2'd0: return 0;
      2'd1: return st;
      2'd3: return !st;
      default: return 1;
    endcase
  endfunction

  function automatic bit refHit(input logic [31:0] ra, input bit st, input logic [31:0] b0,
                                input logic [31:0] b1, input logic [4:0] c);
    bit m0, h0, h1;
    if (c[4]) m0 = ((ra & ~b1) == (b0 & ~b1));
    else      m0 = (ra[31:2] == b0[31:2]);
    h0 = refAllow(c[1:0], st) && m0;
    h1 = !c[4] && refAllow(c[3:2], st) && (ra[31:2] == b1[31:2]);
    return h0 || h1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic applyAcc(input logic [31:0] a, input bit st, input logic [6:0] p, input bit ach,
                          input logic [31:0] b0, input logic [31:0] b1, input logic [4:0] c,
                          input bit dbg, input string tag);
    logic [31:0] ra;
    bit ab, hit;
    accValid = 1; accAddr = a; accStore = st; pidField = p; alignChkEn = ach;
    bpAddr0 = b0; bpAddr1 = b1; bpCtrl = c; dbgEnable = dbg;
    ra  = refReloc(a, p);
    ab  = ach && (a[1:0] != 0);
    hit = !ab && refHit(ra, st, b0, b1, c);
    if (ab) begin expFa = ra; expFs = 11'h400; end
    @(negedge clk);
    chk(relAddr == ra, {"R1 relAddr ", tag}, relAddr, ra);
    chk(outValid == 1'b1, {"R9 outValid ", tag}, {31'd0, outValid}, 32'd1);
    chk(abortPulse == ab, {"R2 abort ", tag}, {31'd0, abortPulse}, {31'd0, ab});
    chk(faultAddr == expFa, {"R2 faultAddr ", tag}, faultAddr, expFa);
    chk(faultStatus == expFs, {"R2 faultStatus ", tag}, {21'd0, faultStatus}, {21'd0, expFs});
    chk(bpHit == hit, {"R3 R5 R6 R8 hit ", tag}, {31'd0, bpHit}, {31'd0, hit});
    chk(moeWe == (hit && dbg), {"R7 moeWe ", tag}, {31'd0, moeWe}, {31'd0, hit && dbg});
    chk(moeCode == ((hit && dbg) ? 3'b010 : 3'b000), {"R7 moeCode ", tag},
        {29'd0, moeCode}, (hit && dbg) ? 32'd2 : 32'd0);
  endtask

  task automatic applyIdle(input string tag);
    accValid = 0; accAddr = $urandom; alignChkEn = 1; accStore = $urandom;
    @(negedge clk);
    chk(!outValid && !bpHit && !abortPulse && !moeWe, {"R9 idle pulses ", tag},
        {28'd0, outValid, bpHit, abortPulse, moeWe}, 32'd0);
    chk(faultAddr == expFa, {"R9 idle faultAddr ", tag}, faultAddr, expFa);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; accValid = 0; accAddr = 0; accStore = 0; pidField = 0; alignChkEn = 0;
    bpAddr0 = 0; bpAddr1 = 0; bpCtrl = 0; dbgEnable = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(relAddr == 0 && faultAddr == 0 && faultStatus == 0, "R9 reset state", relAddr | faultAddr, 0);
    chk(!outValid && !bpHit && !abortPulse && !moeWe && moeCode == 0, "R9 reset pulses",
        {27'd0, outValid, bpHit, abortPulse, moeWe, |moeCode}, 0);

    // R1 relocation cases
    applyAcc(32'h0000_1000, 0, 7'h15, 0, 0, 0, 5'd0, 0, "r1_reloc");
    applyAcc(32'h8000_1000, 0, 7'h15, 0, 0, 0, 5'd0, 0, "r1_top_nonzero");
    applyAcc(32'h0000_2000, 0, 7'h00, 0, 0, 0, 5'd0, 0, "r1_pid_zero");
    // R2 alignment
    applyAcc(32'h0000_1002, 1, 7'h03, 1, 0, 0, 5'd0, 0, "r2_abort");
    applyIdle("r9_after_abort");
    applyAcc(32'h0000_1003, 1, 7'h03, 0, 0, 0, 5'd0, 0, "r2_check_off");
    // R8 misaligned access that would hit
    applyAcc(32'h4000_0101, 1, 0, 1, 32'h4000_0100, 0, 5'b00010, 1, "r8_abort_wins");
    // R3/R4 enables on comparator 0
    applyAcc(32'h4000_0100, 1, 0, 0, 32'h4000_0100, 0, 5'b00001, 1, "r3_store_only_st");
    applyAcc(32'h4000_0100, 0, 0, 0, 32'h4000_0100, 0, 5'b00001, 1, "r3_store_only_ld");
    applyAcc(32'h4000_0100, 0, 0, 0, 32'h4000_0100, 0, 5'b00011, 1, "r3_load_only_ld");
    applyAcc(32'h4000_0100, 1, 0, 0, 32'h4000_0100, 0, 5'b00011, 1, "r3_load_only_st");
    applyAcc(32'h4000_0100, 0, 0, 0, 32'h4000_0100, 0, 5'b00010, 1, "r3_both_ld");
    applyAcc(32'h4000_0100, 1, 0, 0, 32'h4000_0100, 0, 5'b00000, 1, "r3_off");
    // R4 comparator 1 via bits 3:2
    applyAcc(32'h5000_0200, 1, 0, 0, 0, 32'h5000_0200, 5'b00100, 1, "r4_cmp1_store");
    applyAcc(32'h5000_0200, 0, 0, 0, 0, 32'h5000_0200, 5'b01100, 1, "r4_cmp1_load");
    // R5 low bits ignored
    applyAcc(32'h4000_0103, 1, 0, 0, 32'h4000_0100, 0, 5'b00010, 1, "r5_low_ignored");
    applyAcc(32'h4000_0104, 1, 0, 0, 32'h4000_0100, 0, 5'b00010, 1, "r5_next_word");
    // R6 mask mode
    applyAcc(32'h1234_56AB, 0, 0, 0, 32'h1234_5600, 32'h0000_00FF, 5'b10010, 1, "r6_masked_hit");
    applyAcc(32'h1234_5700, 0, 0, 0, 32'h1234_5600, 32'h0000_00FF, 5'b10010, 1, "r6_outside_mask");
    applyAcc(32'h1234_5601, 0, 0, 0, 32'h1234_5600, 32'h0000_0000, 5'b10010, 1, "r6_low_bits_compared");
    applyAcc(32'h0000_00FF, 0, 0, 0, 32'h7000_0000, 32'h0000_00FF, 5'b11000, 1, "r6_cmp1_off");
    // R7 debug disabled
    applyAcc(32'h4000_0100, 1, 0, 0, 32'h4000_0100, 0, 5'b00010, 0, "r7_dbg_off");
    applyIdle("r9_idle");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b0, b1;
      logic [6:0] p;
      logic [4:0] c;
      b0 = $urandom; b1 = $urandom;
      if ($urandom_range(1, 0) == 1) b0[31:25] = 7'd0;
      if ($urandom_range(3, 0) == 0) b1 = {24'd0, 8'($urandom)};
      p = ($urandom_range(2, 0) == 0) ? 7'd0 : 7'($urandom);
      case ($urandom_range(3, 0))
        0: a = refReloc(b0, p) ^ {30'd0, 2'($urandom)};
        1: a = b1 ^ {30'd0, 2'($urandom)};
        2: a = {7'd0, 25'($urandom)};
        default: a = $urandom;
      endcase
      if ($urandom_range(1, 0) == 1) a[31:25] = 7'd0;
      if ($urandom_range(1, 0) == 1) a[1:0] = 2'd0;
      c = 5'($urandom);
      applyAcc(a, 1'($urandom), p, ($urandom_range(3, 0) == 0), b0, b1, c, 1'($urandom), "rand");
      if ($urandom_range(15, 0) == 0) applyIdle("rand_idle");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule